// File: doc/BRIEF.md
# Dual-Channel Pulse-Width Modulator with Register Access

This peripheral holds two independent pulse-width channels behind a single-cycle 32-bit register port. The port has a word address, write data, a write strobe and a combinational read-data return. Each channel takes tick strobes from its own external rate generator. It also takes that generator's raw square wave. The block supplies each generator with a 16-bit control word, which software loads one byte at a time.

A running channel counts ticks through a repeating cycle of `period+1` ticks. Its waveform is high for the first `on` ticks of each cycle. A per-channel select bit chooses what reaches the pin: this counted waveform, or the raw rate-generator signal. A force bit overrides the level, and a start bit gates the level. The pin enable follows an enable-bar bit and an open-drain bit.

New `on` and `period` values wait in staging registers. They move into the counter's working copy only at a cycle boundary, or while the channel is stopped, so a running waveform never produces a shortened or stretched cycle.

Top module: `pwm_pair_ctrl`

## Requirements
- R1: After reset the word at 0x00 reads 0x22 (both enable-bar bits set), every other register reads 0, both `pwm_oe` bits are 0, both `pwm_out` bits are 0, and `rate_cword` is 0.
- R2: Word addresses, with ch as the channel (0 or 1): 0x00 shared control, 0x04 output select, 0x08+8*ch control-word upper byte, 0x0C+8*ch control-word lower byte, 0x18+8*ch on, 0x1C+8*ch period. The shared control keeps bits 7:0, the output select keeps bits 0 and 4, and the byte registers keep bits 7:0. Other bits and other addresses read 0.
- R3: `rate_cword[16*ch+15:16*ch]` equals {upper byte, lower byte} of channel ch.
- R4: With start=1, select=1, force=0 and a tick every cycle, the output repeats with period+1 cycles and is high on the first `on` cycles after the count wraps to 0.
- R5: When on > period the output is high for the whole cycle, including on=255 with period=254; on=0 gives a constant low.
- R6: The channel counter advances only in cycles in which `rate_tick[ch]` is 1.
- R7: Control bits of channel ch are at 4*ch: +0 start, +1 enable-bar, +2 force-high, +3 open-drain. While start=0 the counter is held at 0 and the output is low; after start rises, the first cycle has count 0.
- R8: on or period written while a channel runs take effect at the next wrap of its counter.
- R9: With select bit 4*ch clear and start=1, `pwm_out[ch]` follows `rate_raw[ch]`.
- R10: Force-high drives `pwm_out[ch]` to 1 whatever the start, select and counter state.
- R11: `pwm_oe[ch]` is 0 when enable-bar is set; otherwise it is 1, except with open-drain set, where it is the inverse of `pwm_out[ch]`.
- R12: Writing one channel's registers or ticks leaves the other channel's waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Byte address of a 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rate_tick | input | 2 | Per-channel tick strobes from the rate generators |
| rate_raw | input | 2 | Per-channel raw rate-generator signals |
| rate_cword | output | 32 | Control words, channel 1 in bits 31:16 |
| pwm_out | output | 2 | Per-channel output level |
| pwm_oe | output | 2 | Per-channel pin drive enable |

## Verification
The properties assume that `rate_tick` and `rate_raw` are synchronous to `clk` and change only between edges. They also assume that a write lasts exactly one cycle, so a counter's working period changes only when the counter itself returns to zero. The stimulus drives every input on the falling edge and pulses the write strobe for one cycle per access. It holds ticks constant within each scenario and samples outputs on the falling edge, where the counter state is settled.

// File: rtl/pwm_pair_ctrl.sv
module pwm_pair_ctrl #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic          bus_we,
  output logic [31:0]   bus_rdata,
  input  logic [1:0]    rate_tick,
  input  logic [1:0]    rate_raw,
  output logic [31:0]   rate_cword,
  output logic [1:0]    pwm_out,
  output logic [1:0]    pwm_oe
);
  localparam int NCH = 2;
  localparam int BW  = 8;
  localparam int CW  = 2 * BW;
  localparam int FS  = 4;
  localparam logic [7:0] CTRL_RST = 8'h22;

  logic [AW-3:0]       widx;
  logic [FS*NCH-1:0]   ctrl_q;
  logic [NCH-1:0]      sel_q;
  logic [CW*NCH-1:0]   cw_flat;
  logic [BW*NCH-1:0]   on_flat, per_flat, cnt_flat, per_act_flat;

  assign widx       = bus_addr[AW-1:2];
  assign rate_cword = cw_flat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      sel_q  <= '0;
    end else if (bus_we) begin
      if (widx == 0) ctrl_q <= bus_wdata[FS*NCH-1:0];
      if (widx == 1) sel_q  <= {bus_wdata[FS], bus_wdata[0]};
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam int B = FS * ch;
    logic          start, oeb, frc, od, wave, lvl;
    logic [BW-1:0] cw_hi, cw_lo, on_r, per_r, on_a, per_a, cnt;

    assign start = ctrl_q[B];
    assign oeb   = ctrl_q[B+1];
    assign frc   = ctrl_q[B+2];
    assign od    = ctrl_q[B+3];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cw_hi <= '0; cw_lo <= '0; on_r <= '0; per_r <= '0;
      end else if (bus_we) begin
        if (widx == 2 + 2*ch) cw_hi <= bus_wdata[BW-1:0];
        if (widx == 3 + 2*ch) cw_lo <= bus_wdata[BW-1:0];
        if (widx == 6 + 2*ch) on_r  <= bus_wdata[BW-1:0];
        if (widx == 7 + 2*ch) per_r <= bus_wdata[BW-1:0];
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt <= '0; on_a <= '0; per_a <= '0;
      end else if (!start) begin
        cnt <= '0; on_a <= on_r; per_a <= per_r;
      end else if (rate_tick[ch]) begin
        if (cnt == per_a) begin
          cnt <= '0; on_a <= on_r; per_a <= per_r;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign wave = cnt < on_a;
    assign lvl  = frc | (start & (sel_q[ch] ? wave : rate_raw[ch]));
    assign pwm_out[ch] = lvl;
    assign pwm_oe[ch]  = ~oeb & (~od | ~lvl);

    assign cw_flat[CW*ch +: CW]      = {cw_hi, cw_lo};
    assign on_flat[BW*ch +: BW]      = on_r;
    assign per_flat[BW*ch +: BW]     = per_r;
    assign cnt_flat[BW*ch +: BW]     = cnt;
    assign per_act_flat[BW*ch +: BW] = per_a;
  end

  always_comb begin
    bus_rdata = '0;
    case (widx)
      0: bus_rdata[FS*NCH-1:0] = ctrl_q;
      1: begin bus_rdata[0] = sel_q[0]; bus_rdata[FS] = sel_q[1]; end
      2: bus_rdata[BW-1:0] = cw_flat[CW-1:BW];
      3: bus_rdata[BW-1:0] = cw_flat[BW-1:0];
      4: bus_rdata[BW-1:0] = cw_flat[2*CW-1:CW+BW];
      5: bus_rdata[BW-1:0] = cw_flat[CW+BW-1:CW];
      6: bus_rdata[BW-1:0] = on_flat[BW-1:0];
      7: bus_rdata[BW-1:0] = per_flat[BW-1:0];
      8: bus_rdata[BW-1:0] = on_flat[2*BW-1:BW];
      9: bus_rdata[BW-1:0] = per_flat[2*BW-1:BW];
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pwm_pair_ctrl_chk.sv
module pwm_pair_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  ctrl_q,
  input logic [1:0]  rate_tick,
  input logic [1:0]  pwm_out,
  input logic [1:0]  pwm_oe,
  input logic [15:0] cnt_flat,
  input logic [15:0] per_act_flat
);
  for (genvar ch = 0; ch < 2; ch++) begin : g_a
    // R4
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_flat[8*ch +: 8] <= per_act_flat[8*ch +: 8]);
    // R7
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[4*ch] |=> cnt_flat[8*ch +: 8] == 8'd0);
    // R6
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[4*ch] && !rate_tick[ch]) |=> $stable(cnt_flat[8*ch +: 8]));
    // R10
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[4*ch+2] |-> pwm_out[ch]);
    // R11
    oeb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[4*ch+1] |-> !pwm_oe[ch]);
    // R11
    open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[4*ch+3] && !ctrl_q[4*ch+1]) |-> (pwm_oe[ch] != pwm_out[ch]));
  end
endmodule

bind pwm_pair_ctrl pwm_pair_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_q(ctrl_q), .rate_tick(rate_tick),
  .pwm_out(pwm_out), .pwm_oe(pwm_oe), .cnt_flat(cnt_flat),
  .per_act_flat(per_act_flat)
);

// File: tb/test_pwm_pair_ctrl.sv
module test_pwm_pair_ctrl;
  logic        clk = 0, rst_n = 0, bus_we = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, rate_cword;
  logic [1:0]  rate_tick = 2'b11, rate_raw = 0, pwm_out, pwm_oe;
  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [7:0] ctl = 8'h22;

  always #4 clk = ~clk;

  pwm_pair_ctrl i_pwm_pair_ctrl (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_rdata(bus_rdata),
    .rate_tick(rate_tick), .rate_raw(rate_raw), .rate_cword(rate_cword),
    .pwm_out(pwm_out), .pwm_oe(pwm_oe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); #1; bus_we = 0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic setctl(input int c, input logic [3:0] f);
    ctl[4*c +: 4] = f; wr(6'h00, {24'd0, ctl});
  endtask

  task automatic prep(input int c, input int on, input int per);
    setctl(c, 4'b0000);
    wr(6'(6'h18 + 8*c), on);
    wr(6'(6'h1C + 8*c), per);
    setctl(c, 4'b0001);
  endtask

  task automatic grab(input int c, input int n, output logic [31:0] v);
    v = 0;
    for (int k = 0; k < n; k++) begin @(negedge clk); v[k] = pwm_out[c]; end
  endtask

  initial begin
    #(8*150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e;
    int hi;
    repeat (3) @(posedge clk);
    #1;
    rd(6'h00, v); chk("R1 ctrl reset", v, 32'h22);
    chk("R1 oe reset", pwm_oe, 0);
    chk("R1 out reset", pwm_out, 0);
    chk("R1 cword reset", rate_cword, 0);
    rd(6'h1C, v); chk("R1 period reset", v, 0);
    rst_n = 1;

    wr(6'h08, 32'h12AB); wr(6'h0C, 32'hFF34);
    wr(6'h10, 32'h00C5); wr(6'h14, 32'h007E);
    chk("R3 cword", rate_cword, 32'hC57E_AB34);
    rd(6'h08, v); chk("R2 msb readback", v, 32'hAB);
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, v); chk("R2 select bits", v, 32'h11);
    wr(6'h20, 32'hFFFF_FF5A);
    rd(6'h20, v); chk("R2 on width", v, 32'h5A);
    rd(6'h28, v); chk("R2 unused addr", v, 0);
    rd(6'h3C, v); chk("R2 unused addr hi", v, 0);

    // R4 R5 sweeps on both channels
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < (c == 0 ? 8 : 4); p++)
        for (int o = 0; o <= p + 2; o++) begin
          prep(c, o, p);
          grab(c, 2*(p+1), v);
          e = 0;
          for (int k = 0; k < 2*(p+1); k++) e[k] = ((k % (p+1)) < o);
          chk(o > p ? "R5 full/zero duty" : "R4 waveform", v, e);
          setctl(c, 4'b0000);
        end

    // R5 widest 100% case
    prep(0, 255, 254);
    hi = 0;
    for (int k = 0; k < 255; k++) begin @(negedge clk); hi += pwm_out[0]; end
    chk("R5 255 over 254", hi, 255);

    // R12 channel 1 unaffected by channel 0 writes
    prep(1, 2, 3);
    wr(6'h18, 1); wr(6'h1C, 6); wr(6'h0C, 0);
    grab(1, 8, v);
    hi = 0;
    for (int k = 0; k < 8; k++) hi += v[k];
    chk("R12 ch1 duty", hi, 4);

    // R8 boundary update
    prep(0, 2, 3);
    wr(6'h18, 4); wr(6'h1C, 5);
    grab(0, 8, v);
    chk("R8 boundary", v, 32'b1100_0011 ^ 32'hFF);

    // R7 stop holds low
    setctl(0, 4'b0000);
    grab(0, 6, v);
    chk("R7 stopped low", v, 0);

    // R6 no ticks
    rate_tick[0] = 0;
    prep(0, 1, 3);
    grab(0, 10, v);
    chk("R6 frozen", v, 32'h3FF);
    rate_tick[0] = 1;
    setctl(0, 4'b0000);

    // R9 raw path
    wr(6'h04, 32'h10);
    setctl(0, 4'b0001);
    rate_raw[0] = 1; #1; chk("R9 raw high", pwm_out[0], 1);
    rate_raw[0] = 0; #1; chk("R9 raw low", pwm_out[0], 0);
    setctl(0, 4'b0000);
    wr(6'h04, 32'h11);

    // R10 force with start clear
    setctl(0, 4'b0100);
    @(negedge clk); chk("R10 force", pwm_out[0], 1);

    // R11 enable-bar and open drain
    setctl(0, 4'b0110);
    @(negedge clk); chk("R11 oeb", pwm_oe[0], 0);
    wr(6'h18, 1); wr(6'h1C, 1);
    setctl(0, 4'b1001);
    grab(0, 2, v);
    chk("R11 od wave", v, 32'b01);
    setctl(0, 4'b1001);
    @(negedge clk);
    chk("R11 od oe", {pwm_out[0], pwm_oe[0]} == 2'b10 || {pwm_out[0], pwm_oe[0]} == 2'b01, 1);
    setctl(0, 4'b0001);
    @(negedge clk); chk("R11 push-pull oe", pwm_oe[0], 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule